// File: doc/BRIEF.md
# Sparse Hit-Pattern Readout Sequencer

This block sits behind a group of 32 time digitizers. When the conversion-complete pulse arrives, it captures each channel's hit flag and its 10-bit time word. From then on the hit flags form a frozen 32-bit pattern, which holds until a fast clear or a reset. Trigger logic reads the pattern on a parallel pad port. That port uses negative logic and is driven only while its active-low enable is asserted. The pad driver is modelled as an output-enable signal plus a data vector.

A readout request makes the block send one word for each hit channel, in ascending channel order, followed by an end-of-block marker word. Channels with no hit produce no word. A group with no hits produces only the marker. The word stream is valid/ready. A word is transferred on a cycle where valid and ready are both high. While valid is high and ready is low, the word is held unchanged, and valid does not fall until the word has been taken. No word is dropped or repeated. A readout request that arrives before conversion is held until conversion completes. Fast clear overrides every other input.

Top module: `hit_readout_seq`

## Requirements
- R1: After reset, no word is offered (valid low) and the pattern is empty, so an enabled pattern port reads all ones.
- R2: A conversion-complete pulse captures the hit flags and time words. Later pulses, and later changes on the hit and time inputs, have no effect until a fast clear or reset.
- R3: The pattern port drives (output-enable high) exactly while the enable input is low. Bit n of the port data is 0 when channel n was captured with a hit, and 1 otherwise.
- R4: A readout emits one word per hit channel, in ascending channel order. Each word carries the 5-bit channel index and the channel's captured 10-bit time, with the marker flag 0.
- R5: After the last channel word, one marker word follows with the marker flag 1 and the channel and time fields 0. A group with no hits emits only the marker.
- R6: While valid is high and ready is low, valid stays high and the channel, time and marker fields stay unchanged.
- R7: A request made before conversion completes is held, and its readout starts once conversion completes. A request made while a readout is in progress is ignored.
- R8: Fast clear empties the pattern, drops any held request and aborts a readout in progress (valid low on the next cycle). It takes priority over a conversion-complete pulse in the same cycle.
- R9: Readout does not alter the pattern. A later request reads the same words again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 32 | Per-channel hit flags |
| time_i | input | 320 | Per-channel 10-bit time words, channel n at bits [10n+9:10n] |
| conv_done_i | input | 1 | Conversion-complete pulse |
| pat_en_n_i | input | 1 | Active-low enable for the pattern port |
| fclr_i | input | 1 | Fast clear |
| rd_req_i | input | 1 | Readout request pulse |
| pat_oe_o | output | 1 | Pattern pad output enable |
| pat_n_o | output | 32 | Low-true hit pattern (all ones when not driven) |
| m_valid_o | output | 1 | Stream word valid |
| m_ready_i | input | 1 | Stream word ready |
| m_chan_o | output | 5 | Channel index of the word |
| m_time_o | output | 10 | Time of the word |
| m_last_o | output | 1 | End-of-block marker flag |

## Verification
Fast clear can land in the same cycle as a conversion-complete pulse. It can also land in the middle of a readout while ready is being toggled. The bench provokes both cases deliberately. The bench model gives fast clear precedence. It expects an empty pattern afterwards, so a later request yields only the marker. After an aborted readout it expects valid to be low on the next cycle. Pseudo-random back-pressure runs through the readouts. Every cycle is compared against a queue of expected words, which catches any word that is lost, repeated or changed.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  typedef enum logic {RD_IDLE = 1'b0, RD_SEND = 1'b1} rd_state_e;
endpackage

// File: rtl/hrs_capture.sv
// Freezes hit flags and time words at conversion complete.
module hrs_capture #(
  parameter int NCH = 32,
  parameter int TW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fclr,
  input  logic              conv_done,
  input  logic [NCH-1:0]    hit,
  input  logic [NCH*TW-1:0] times,
  output logic [NCH-1:0]    pattern,
  output logic [NCH*TW-1:0] times_q,
  output logic              frozen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pattern <= '0;
      times_q <= '0;
      frozen  <= 1'b0;
    end else if (fclr) begin
      pattern <= '0;
      frozen  <= 1'b0;
    end else if (conv_done && !frozen) begin
      pattern <= hit;
      times_q <= times;
      frozen  <= 1'b1;
    end
  end
endmodule

// File: rtl/hrs_pad.sv
// Low-true pattern pad model: output enable plus data.
module hrs_pad #(
  parameter int NCH = 32
) (
  input  logic           en_n,
  input  logic [NCH-1:0] pattern,
  output logic           oe,
  output logic [NCH-1:0] pat_n
);
  always_comb begin
    oe    = ~en_n;
    pat_n = oe ? ~pattern : '1;
  end
endmodule

// File: rtl/hrs_scan.sv
// Lowest-set-bit finder over the remaining hit mask.
module hrs_scan #(
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  output logic           any,
  output logic [CW-1:0]  idx
);
  always_comb begin
    any = |mask;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) idx = CW'(i);
    end
  end
endmodule

// File: rtl/hit_readout_seq.sv
module hit_readout_seq #(
  parameter int NCH = 32,
  parameter int TW  = 10,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    hit_i,
  input  logic [NCH*TW-1:0] time_i,
  input  logic              conv_done_i,
  input  logic              pat_en_n_i,
  input  logic              fclr_i,
  input  logic              rd_req_i,
  output logic              pat_oe_o,
  output logic [NCH-1:0]    pat_n_o,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [CW-1:0]     m_chan_o,
  output logic [TW-1:0]     m_time_o,
  output logic              m_last_o
);
  import hrs_pkg::*;

  logic [NCH-1:0]    pattern;
  logic [NCH*TW-1:0] times_q;
  logic              frozen;
  rd_state_e         state_q;
  logic [NCH-1:0]    rem_q;
  logic              pend_q;
  logic              any;
  logic [CW-1:0]     idx;
  logic              start;
  logic              accept;

  hrs_capture #(.NCH(NCH), .TW(TW)) u_cap (
    .clk(clk), .rst_n(rst_n), .fclr(fclr_i), .conv_done(conv_done_i),
    .hit(hit_i), .times(time_i), .pattern(pattern), .times_q(times_q),
    .frozen(frozen)
  );

  hrs_pad #(.NCH(NCH)) u_pad (
    .en_n(pat_en_n_i), .pattern(pattern), .oe(pat_oe_o), .pat_n(pat_n_o)
  );

  hrs_scan #(.NCH(NCH)) u_scan (.mask(rem_q), .any(any), .idx(idx));

  assign start  = (state_q == RD_IDLE) && pend_q && frozen;
  assign accept = m_valid_o && m_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      rem_q   <= '0;
      pend_q  <= 1'b0;
    end else if (fclr_i) begin
      state_q <= RD_IDLE;
      rem_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (start) begin
        state_q <= RD_SEND;
        rem_q   <= pattern;
        pend_q  <= 1'b0;
      end else if (rd_req_i && state_q == RD_IDLE) begin
        pend_q <= 1'b1;
      end
      if (state_q == RD_SEND && accept) begin
        if (any) rem_q <= rem_q & ~(NCH'(1) << idx);
        else     state_q <= RD_IDLE;
      end
    end
  end

  always_comb begin
    m_valid_o = (state_q == RD_SEND);
    m_last_o  = m_valid_o && !any;
    m_chan_o  = (m_valid_o && any) ? idx : '0;
    m_time_o  = (m_valid_o && any) ? times_q[idx*TW +: TW] : '0;
  end
endmodule

// File: rtl/hrs_checker.sv
module hrs_checker #(
  parameter int NCH = 32,
  parameter int TW  = 10,
  localparam int CW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fclr_i,
  input logic           pat_oe_o,
  input logic [NCH-1:0] pat_n_o,
  input logic           m_valid_o,
  input logic           m_ready_i,
  input logic [CW-1:0]  m_chan_o,
  input logic [TW-1:0]  m_time_o,
  input logic           m_last_o
);
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !m_valid_o); // R1
  AST_PATTERN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_oe_o && !fclr_i && !(&pat_n_o)) |=> (!pat_oe_o || $stable(pat_n_o))); // R2
  AST_WORDS_CONTINUE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && m_ready_i && !m_last_o && !fclr_i) |=> m_valid_o); // R4
  AST_MARKER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && m_last_o) |-> (m_chan_o == '0 && m_time_o == '0)); // R5
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i && !fclr_i) |=>
      (m_valid_o && $stable(m_chan_o) && $stable(m_time_o) && $stable(m_last_o))); // R6
  AST_CLEAR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    fclr_i |=> !m_valid_o); // R8
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    fclr_i |=> (!pat_oe_o || (&pat_n_o))); // R8
endmodule

bind hit_readout_seq hrs_checker #(.NCH(NCH), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fclr_i(fclr_i), .pat_oe_o(pat_oe_o),
  .pat_n_o(pat_n_o), .m_valid_o(m_valid_o), .m_ready_i(m_ready_i),
  .m_chan_o(m_chan_o), .m_time_o(m_time_o), .m_last_o(m_last_o)
);

// File: tb/hit_readout_seq_test.sv
module hit_readout_seq_test;
  localparam int NCH = 32;
  localparam int TW  = 10;
  localparam int CW  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    hit_i = '0;
  logic [NCH*TW-1:0] time_i = '0;
  logic              conv_done_i = 1'b0;
  logic              pat_en_n_i = 1'b0;
  logic              fclr_i = 1'b0;
  logic              rd_req_i = 1'b0;
  logic              m_ready_i = 1'b1;
  logic              pat_oe_o;
  logic [NCH-1:0]    pat_n_o;
  logic              m_valid_o;
  logic [CW-1:0]     m_chan_o;
  logic [TW-1:0]     m_time_o;
  logic              m_last_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hit_readout_seq #(.NCH(NCH), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .time_i(time_i),
    .conv_done_i(conv_done_i), .pat_en_n_i(pat_en_n_i), .fclr_i(fclr_i),
    .rd_req_i(rd_req_i), .pat_oe_o(pat_oe_o), .pat_n_o(pat_n_o),
    .m_valid_o(m_valid_o), .m_ready_i(m_ready_i), .m_chan_o(m_chan_o),
    .m_time_o(m_time_o), .m_last_o(m_last_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [NCH-1:0] mpat = '0;
  logic [TW-1:0]  mt [NCH];
  bit mfrz = 0, mpend = 0, mbusy = 0;
  int q[$];
  localparam int MARK = 1 << 20;

  always @(posedge clk) begin
    bit pb, pp, pf;
    int w;
    pb = mbusy; pp = mpend; pf = mfrz;
    if (!rst_n) begin
      mpat = '0; mfrz = 0; mpend = 0; mbusy = 0; q.delete();
    end else if (fclr_i) begin
      mpat = '0; mfrz = 0; mpend = 0; mbusy = 0; q.delete();
    end else begin
      if (pb && m_ready_i) begin
        w = q.pop_front();
        if (w == MARK) mbusy = 0;
      end
      if (!pb && pp && pf) begin
        mbusy = 1; mpend = 0; q.delete();
        for (int c = 0; c < NCH; c++)
          if (mpat[c]) q.push_back((c << TW) | int'(mt[c]));
        q.push_back(MARK);
      end else if (rd_req_i && !pb) begin
        mpend = 1;
      end
      if (conv_done_i && !pf) begin
        mpat = hit_i; mfrz = 1;
        for (int c = 0; c < NCH; c++) mt[c] = time_i[c*TW +: TW];
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int act;
      chk(m_valid_o == mbusy, "R6 valid", m_valid_o, mbusy);
      if (mbusy && m_valid_o && q.size() > 0) begin
        act = (int'(m_last_o) << 20) | (int'(m_chan_o) << TW) | int'(m_time_o);
        chk(act == q[0], (q[0] == MARK) ? "R5 marker" : "R4 word", act, q[0]);
      end
      chk(pat_oe_o == !pat_en_n_i, "R3 oe", pat_oe_o, !pat_en_n_i);
      if (!pat_en_n_i) chk(pat_n_o == ~mpat, "R3 data", pat_n_o, ~mpat);
    end
  end

  // back-pressure source
  logic [15:0] lfsr = 16'hACE1;
  bit bp = 0;
  always @(posedge clk) begin
    #3;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready_i = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic load(input logic [NCH-1:0] h, input int seed);
    hit_i = h;
    for (int c = 0; c < NCH; c++) time_i[c*TW +: TW] = TW'(c * 37 + seed);
    conv_done_i = 1'b1;
    step(1);
    conv_done_i = 1'b0;
  endtask

  task automatic request();
    rd_req_i = 1'b1;
    step(1);
    rd_req_i = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((mbusy || mpend) && guard < 3000) begin
      step(1);
      guard++;
    end
    chk(guard < 3000, "R4 drain", guard, 0);
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk(m_valid_o == 1'b0, "R1 valid", m_valid_o, 0);
    chk(pat_n_o == '1, "R1 pattern", pat_n_o, 32'hFFFFFFFF);

    // R7: request before conversion is held
    request();
    step(5);
    chk(m_valid_o == 1'b0, "R7 held", m_valid_o, 0);
    bp = 1;
    load(32'h8000_0001 | 32'h0012_4400, 5);
    drain();

    // R2: further captures ignored while frozen
    load(32'h0F0F_0F0F, 99);
    hit_i = 32'hFFFF_FFFF;
    step(2);
    chk(pat_n_o == ~(32'h8000_0001 | 32'h0012_4400), "R2 frozen", pat_n_o,
        ~(32'h8000_0001 | 32'h0012_4400));

    // R9: repeat readout, R7: request during readout ignored
    request();
    step(3);
    request();
    drain();
    step(2);
    chk(m_valid_o == 1'b0, "R7 ignored", m_valid_o, 0);

    // R3: disabled port
    pat_en_n_i = 1'b1;
    step(2);
    chk(pat_oe_o == 1'b0, "R3 disabled", pat_oe_o, 0);
    pat_en_n_i = 1'b0;

    // R8: fast clear and conversion in the same cycle
    fclr_i = 1'b1;
    hit_i = 32'hDEAD_BEEF;
    conv_done_i = 1'b1;
    step(1);
    fclr_i = 1'b0;
    conv_done_i = 1'b0;
    step(1);
    chk(pat_n_o == '1, "R8 clear wins", pat_n_o, 32'hFFFFFFFF);

    // R5: empty group yields only the marker
    load('0, 3);
    bp = 0;
    request();
    step(1);
    chk(m_valid_o && m_last_o, "R5 empty", {m_valid_o, m_last_o}, 3);
    drain();

    // R8: fast clear during readout
    fclr_i = 1'b1; step(1); fclr_i = 1'b0;
    load(32'hFFFF_FFFF, 11);
    bp = 1;
    request();
    step(6);
    fclr_i = 1'b1; step(1); fclr_i = 1'b0;
    chk(m_valid_o == 1'b0, "R8 abort", m_valid_o, 0);
    step(2);

    // a few more patterns with back-pressure
    for (int k = 0; k < 6; k++) begin
      fclr_i = 1'b1; step(1); fclr_i = 1'b0;
      load({lfsr, lfsr ^ 16'h5A5A} & {NCH{k[0]}} | (32'h1 << (k * 6)), k * 101);
      request();
      drain();
    end

    step(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule